// File: doc/BRIEF.md
# Debug Halt and Clock-Hold Controller

This block keeps track of whether a small processor core is in its debug state. It also decides which peripheral clock domains stop while the core is in that state. The core enters debug when it reports that it has executed its software break instruction. It also enters debug when the asynchronous break line from the serial debug pin falls low. The core leaves debug when it reports its debug-return instruction. While debug is active, the block raises mask signals that block ordinary hardware interrupts and the non-maskable interrupt.

Two software-writable run-in-debug bits control the two gated domains: the main peripheral clock domain and the secondary oscillator domain. Each bit decides whether its domain keeps running while debug is active. The bits can be rewritten at any time, including during debug, and a write takes effect at once. The clock-enable qualifiers are registered, so they only change at a clock boundary and the downstream clock gates see clean levels.

Domains clocked from an external input clock, and the display driver domain, are never stopped by debug. They therefore get no qualifier from this block. The block also presents the start address of the 64-byte debug work area as a constant.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After synchronous reset, debug is inactive, both mask outputs are 0, both run-in-debug bits are 0 and both clock enables are 1.
- R2: A one-cycle pulse on `brk_exec_i` while debug is inactive, with no return pulse, makes `dbg_active_o` 1 after the next rising edge.
- R3: The break line passes through a two-flop synchronizer and acts on its falling edge. If the line is driven low before rising edge k, debug becomes active at edge k+2. A line that stays low causes only one entry, so after a return it stays inactive.
- R4: Once active, debug stays active until `retd_exec_i` is seen at a rising edge. It is inactive after that edge.
- R5: `irq_mask_o` and `nmi_mask_o` are 1 exactly in the cycles where `dbg_active_o` is 1.
- R6: Clock enable bit 0 (main peripheral domain) is 0 while debug is active and its run bit is 0. Bit 1 (secondary oscillator domain) behaves the same way with its own run bit. A domain whose run bit is 1 keeps its enable at 1 during debug.
- R7: `cfg_we_i[i]` loads `cfg_wdata_i[i]` into run bit i, where bit 0 is the main domain and bit 1 is the oscillator domain. The new value is reflected on `dom_clk_en_o[i]` after the same edge, including while debug is active.
- R8: A break instruction pulse or a break-line falling edge that arrives while debug is active has no effect.
- R9: When a return and a break request fall in the same cycle, the return wins, so debug is inactive afterwards whatever the prior state. A return while debug is inactive has no effect.
- R10: The clock enables are register outputs that change only at rising edges. Outside debug, both are 1.
- R11: `work_base_o` always equals the parameter `WORK_BASE` (default 24'h000FC0). That value is aligned to the 64-byte size of the work area.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_exec_i | input | 1 | Core executed the software break instruction (one-cycle pulse) |
| retd_exec_i | input | 1 | Core executed the debug-return instruction (one-cycle pulse) |
| brk_line_i | input | 1 | Asynchronous break line from the debug data pin, active low |
| cfg_we_i | input | 2 | Per-domain write strobe for the run-in-debug bits |
| cfg_wdata_i | input | 2 | Write data for the run-in-debug bits |
| dbg_active_o | output | 1 | Core is in debug |
| irq_mask_o | output | 1 | Blocks ordinary hardware interrupts |
| nmi_mask_o | output | 1 | Blocks the non-maskable interrupt |
| dom_clk_en_o | output | 2 | Registered clock enables: bit 0 main peripheral, bit 1 secondary oscillator |
| work_base_o | output | 24 | Start address of the 64-byte debug work area |

## Verification
A wrong mode register shows up on the mask outputs and both clock enables in the very next cycle. A run bit that loses or ignores a write shows up on that domain's enable only while debug is active. The tests therefore write during debug and compare the enables after that same edge. An edge detector that retriggers on a held line, or that has the wrong synchronizer depth, is caught at the ports. A held line would re-enter debug after a return, and the wrong depth would move entry away from the second edge after the first sample.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    localparam int NUM_DOM   = 2;
    localparam int DOM_MAIN  = 0;
    localparam int DOM_OSC   = 1;
    localparam int ADDR_W    = 24;
    localparam int WORK_SIZE = 64;
    localparam int WORK_ALGN = $clog2(WORK_SIZE);

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_HALT = 1'b1
    } mode_e;

    typedef struct packed {
        logic brk_sw;
        logic brk_pin;
        logic ret;
    } dbg_req_t;

    // Return has priority over any entry request.
    function automatic mode_e next_mode(input mode_e cur, input dbg_req_t r);
        mode_e n;
        if (r.ret)
            n = MODE_RUN;
        else if (cur == MODE_HALT)
            n = MODE_HALT;
        else if (r.brk_sw || r.brk_pin)
            n = MODE_HALT;
        else
            n = MODE_RUN;
        return n;
    endfunction

    function automatic logic dom_enable(input mode_e m, input logic run_bit);
        return (m == MODE_RUN) || run_bit;
    endfunction

endpackage

// File: rtl/dbgc_brk_sync.sv
module dbgc_brk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            prev_q <= sync_q[LAST];
        end
    end

    assign fall_o = prev_q & ~sync_q[LAST];

endmodule

// File: rtl/dbgc_mode_fsm.sv
module dbgc_mode_fsm
    import dbgc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dbg_req_t req_i,
    output mode_e    mode_o,
    output mode_e    mode_nxt_o
);
    mode_e mode_q;
    mode_e mode_d;

    always_comb mode_d = next_mode(mode_q, req_i);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RUN;
        else     mode_q <= mode_d;
    end

    assign mode_o     = mode_q;
    assign mode_nxt_o = mode_d;

endmodule

// File: rtl/dbgc_run_cfg.sv
module dbgc_run_cfg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] run_o,
    output logic [N-1:0] run_nxt_o
);
    logic [N-1:0] run_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign run_nxt_o[i] = we_i[i] ? wdata_i[i] : run_q[i];
        always_ff @(posedge clk) begin
            if (rst) run_q[i] <= 1'b0;
            else     run_q[i] <= run_nxt_o[i];
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/dbgc_clk_qual.sv
module dbgc_clk_qual
    import dbgc_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode_nxt_i,
    input  logic [N-1:0] run_nxt_i,
    output logic [N-1:0] en_o
);
    logic [N-1:0] en_q;

    for (genvar i = 0; i < N; i++) begin : g_dom
        always_ff @(posedge clk) begin
            if (rst) en_q[i] <= 1'b1;
            else     en_q[i] <= dom_enable(mode_nxt_i, run_nxt_i[i]);
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbgc_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] WORK_BASE   = 24'h000FC0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               brk_exec_i,
    input  logic               retd_exec_i,
    input  logic               brk_line_i,
    input  logic [NUM_DOM-1:0] cfg_we_i,
    input  logic [NUM_DOM-1:0] cfg_wdata_i,
    output logic               dbg_active_o,
    output logic               irq_mask_o,
    output logic               nmi_mask_o,
    output logic [NUM_DOM-1:0] dom_clk_en_o,
    output logic [ADDR_W-1:0]  work_base_o
);
    logic               pin_fall;
    dbg_req_t           req;
    mode_e              mode_cur;
    mode_e              mode_nxt;
    logic [NUM_DOM-1:0] run_cur;
    logic [NUM_DOM-1:0] run_nxt;

    dbgc_brk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (brk_line_i),
        .fall_o (pin_fall)
    );

    always_comb begin
        req.brk_sw  = brk_exec_i;
        req.brk_pin = pin_fall;
        req.ret     = retd_exec_i;
    end

    dbgc_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .mode_o     (mode_cur),
        .mode_nxt_o (mode_nxt)
    );

    dbgc_run_cfg #(.N(NUM_DOM)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we_i      (cfg_we_i),
        .wdata_i   (cfg_wdata_i),
        .run_o     (run_cur),
        .run_nxt_o (run_nxt)
    );

    dbgc_clk_qual #(.N(NUM_DOM)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .mode_nxt_i (mode_nxt),
        .run_nxt_i  (run_nxt),
        .en_o       (dom_clk_en_o)
    );

    assign dbg_active_o = (mode_cur == MODE_HALT);
    assign irq_mask_o   = (mode_cur == MODE_HALT);
    assign nmi_mask_o   = (mode_cur == MODE_HALT);
    assign work_base_o  = WORK_BASE;

endmodule

// File: rtl/dbgc_chk.sv
module dbgc_chk
    import dbgc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               brk_exec_i,
    input logic               retd_exec_i,
    input logic               pin_fall,
    input logic               dbg_active_o,
    input logic               irq_mask_o,
    input logic               nmi_mask_o,
    input logic [NUM_DOM-1:0] dom_clk_en_o,
    input logic [NUM_DOM-1:0] run_cur
);
    p_enter_sw_r2: assert property (@(posedge clk) disable iff (rst)
        (!dbg_active_o && brk_exec_i && !retd_exec_i) |=> dbg_active_o);

    p_enter_pin_r3: assert property (@(posedge clk) disable iff (rst)
        (!dbg_active_o && pin_fall && !retd_exec_i) |=> dbg_active_o);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (dbg_active_o && !retd_exec_i) |=> dbg_active_o);

    p_ret_wins_r9: assert property (@(posedge clk) disable iff (rst)
        retd_exec_i |=> !dbg_active_o);

    p_mask_drop_r5: assert property (@(posedge clk) disable iff (rst)
        retd_exec_i |=> (!irq_mask_o && !nmi_mask_o));

    p_mask_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_active_o) |-> (irq_mask_o && nmi_mask_o));

    p_freeze_main_r6: assert property (@(posedge clk) disable iff (rst)
        (dbg_active_o && !run_cur[DOM_MAIN]) |-> !dom_clk_en_o[DOM_MAIN]);

    p_freeze_osc_r6: assert property (@(posedge clk) disable iff (rst)
        (dbg_active_o && !run_cur[DOM_OSC]) |-> !dom_clk_en_o[DOM_OSC]);

    p_run_live_r7: assert property (@(posedge clk) disable iff (rst)
        (dbg_active_o && run_cur[DOM_MAIN]) |-> dom_clk_en_o[DOM_MAIN]);

    p_free_outside_r10: assert property (@(posedge clk) disable iff (rst)
        !dbg_active_o |-> (dom_clk_en_o == '1));

endmodule

bind dbg_halt_ctrl dbgc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .brk_exec_i   (brk_exec_i),
    .retd_exec_i  (retd_exec_i),
    .pin_fall     (pin_fall),
    .dbg_active_o (dbg_active_o),
    .irq_mask_o   (irq_mask_o),
    .nmi_mask_o   (nmi_mask_o),
    .dom_clk_en_o (dom_clk_en_o),
    .run_cur      (run_cur)
);

// File: tb/tb_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_halt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        brk_exec_i = 1'b0;
    logic        retd_exec_i = 1'b0;
    logic        brk_line_i = 1'b1;
    logic [1:0]  cfg_we_i = '0;
    logic [1:0]  cfg_wdata_i = '0;
    logic        dbg_active_o;
    logic        irq_mask_o;
    logic        nmi_mask_o;
    logic [1:0]  dom_clk_en_o;
    logic [23:0] work_base_o;

    always #2.5 clk = ~clk;

    dbg_halt_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .brk_exec_i   (brk_exec_i),
        .retd_exec_i  (retd_exec_i),
        .brk_line_i   (brk_line_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .dbg_active_o (dbg_active_o),
        .irq_mask_o   (irq_mask_o),
        .nmi_mask_o   (nmi_mask_o),
        .dom_clk_en_o (dom_clk_en_o),
        .work_base_o  (work_base_o)
    );

    typedef struct {
        logic       dbg;
        logic [1:0] en;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, queues the state expected after that edge.
    task automatic step(input logic bs, input logic rt, input logic pn,
                        input logic [1:0] we, input logic [1:0] wd,
                        input logic ed, input logic [1:0] een, input string tag);
        exp_t e;
        @(negedge clk);
        brk_exec_i  = bs;
        retd_exec_i = rt;
        brk_line_i  = pn;
        cfg_we_i    = we;
        cfg_wdata_i = wd;
        @(posedge clk);
        #1;
        e.dbg = ed; e.en = een; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares outputs away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(dbg_active_o == e.dbg, {e.tag, " dbg"},
                      $sformatf("%0b", dbg_active_o), $sformatf("%0b", e.dbg));
                check(irq_mask_o == e.dbg && nmi_mask_o == e.dbg, {e.tag, " R5 masks"},
                      $sformatf("%0b%0b", irq_mask_o, nmi_mask_o), $sformatf("%0b%0b", e.dbg, e.dbg));
                check(dom_clk_en_o == e.en, {e.tag, " clk_en"},
                      $sformatf("%b", dom_clk_en_o), $sformatf("%b", e.en));
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!dbg_active_o && !irq_mask_o && !nmi_mask_o && dom_clk_en_o == 2'b11, "R1 reset",
              $sformatf("%0b%0b%0b%b", dbg_active_o, irq_mask_o, nmi_mask_o, dom_clk_en_o), "00011");
        check(work_base_o == 24'h000FC0 && work_base_o[5:0] == 6'd0, "R11 work base",
              $sformatf("%h", work_base_o), "000fc0");

        step(0,0,1, 2'b00,2'b00, 0,2'b11, "R1 idle");
        // software break entry, both run bits 0 -> both frozen
        step(1,0,1, 2'b00,2'b00, 1,2'b00, "R2 brk entry R6");
        step(0,0,1, 2'b00,2'b00, 1,2'b00, "R4 hold");
        step(1,0,1, 2'b00,2'b00, 1,2'b00, "R8 brk in debug");
        // live writes during debug
        step(0,0,1, 2'b01,2'b01, 1,2'b01, "R7 main run write");
        step(0,0,1, 2'b10,2'b10, 1,2'b11, "R7 osc run write");
        step(0,0,1, 2'b00,2'b00, 1,2'b11, "R6 running domains");
        step(0,1,1, 2'b00,2'b00, 0,2'b11, "R4 return");
        step(1,0,1, 2'b00,2'b00, 1,2'b11, "R7 bits kept");
        step(0,0,1, 2'b11,2'b00, 1,2'b00, "R7 clear both");
        step(0,0,1, 2'b01,2'b01, 1,2'b01, "R6 main only");
        step(0,1,1, 2'b00,2'b00, 0,2'b11, "R10 free after return");
        step(0,0,1, 2'b01,2'b00, 0,2'b11, "R10 write outside debug");
        // simultaneous entry and return
        step(1,1,1, 2'b00,2'b00, 0,2'b11, "R9 ret wins idle");
        step(0,1,1, 2'b00,2'b00, 0,2'b11, "R9 ret outside");
        step(1,0,1, 2'b00,2'b00, 1,2'b00, "R2 re-entry");
        step(1,1,1, 2'b00,2'b00, 0,2'b11, "R9 ret wins active");
        // break line: low before edge k -> active after edge k+2
        step(0,0,0, 2'b00,2'b00, 0,2'b11, "R3 sync 1");
        step(0,0,0, 2'b00,2'b00, 0,2'b11, "R3 sync 2");
        step(0,0,0, 2'b00,2'b00, 1,2'b00, "R3 pin entry");
        step(0,1,0, 2'b00,2'b00, 0,2'b11, "R4 return pin");
        for (int i = 0; i < 4; i++)
            step(0,0,0, 2'b00,2'b00, 0,2'b11, "R3 held low single");
        for (int i = 0; i < 3; i++)
            step(0,0,1, 2'b00,2'b00, 0,2'b11, "R3 release");
        // pin edge while already in debug
        step(1,0,1, 2'b00,2'b00, 1,2'b00, "R2 entry");
        for (int i = 0; i < 4; i++)
            step(0,0,0, 2'b00,2'b00, 1,2'b00, "R8 pin in debug");
        step(0,1,0, 2'b00,2'b00, 0,2'b11, "R8 return");
        for (int i = 0; i < 3; i++)
            step(0,0,0, 2'b00,2'b00, 0,2'b11, "R8 no late entry");
        step(0,0,1, 2'b00,2'b00, 0,2'b11, "R1 idle end");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule